// File: doc/BRIEF.md
# Programmable High/Low Phase Clock Divider

This block divides a fast base clock by a programmable ratio. One 8-bit setting holds two fields. Each field gives the length of one output phase in base cycles, minus one. The divisor is therefore the sum of the two phase lengths, and the duty cycle follows the setting. The divided clock comes out of a register. A one-cycle rise strobe marks the first base cycle of every high phase. Both outputs are synchronous to the base clock.

Software may write a new setting at any time. The write goes into a pending register. The divider adopts the pending value only when a complete low phase has ended, so a period already in progress keeps its length. The block also reports the divisor of the setting in use. A low-power mode input parks the divider in an idle state and raises a bypass flag, which tells the surrounding logic to select an always-on alternate clock instead of this output.

Top module: `phase_clk_div`

## Requirements
- R1: With setting bits [7:4] equal to H, each high phase of `clkOut` lasts exactly H+1 base-clock cycles.
- R2: With setting bits [3:0] equal to L, each low phase of `clkOut` lasts exactly L+1 base-clock cycles.
- R3: While reset is applied, and directly after it, these values hold: the setting in use is 0x00, `clkOut` and `riseStrobe` are low, `bypassActive` is low, and `divisorOut` reads 2.
- R4: After reset is released, the first base-clock edge with `lowPowerMode` low starts a high phase, so `clkOut` and `riseStrobe` are high after that edge.
- R5: `riseStrobe` is high for exactly one base cycle in each output period. That cycle is the first cycle of the high phase.
- R6: A setting written while a period is in progress does not change that period. The setting takes effect from the next high phase, after the current low phase has completed.
- R7: `divisorOut` equals H+L+2 for the setting that is currently shaping the output.
- R8: While `lowPowerMode` is high, `bypassActive` is high from the next edge on. In the same mode `clkOut` stays low, no rise strobe occurs and the phase counter holds its value.
- R9: When `lowPowerMode` falls, the next edge starts a high phase that uses the most recently written setting, including a setting written during bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the phase setting |
| cfgWrData | input | 8 | New setting: [7:4] high length minus one, [3:0] low length minus one |
| lowPowerMode | input | 1 | Requests the idle bypass state |
| clkOut | output | 1 | Divided clock, registered |
| riseStrobe | output | 1 | One-cycle pulse at the start of each high phase |
| divisorOut | output | 6 | Divisor of the setting in use |
| bypassActive | output | 1 | High while the alternate source should be used |

## Verification
On every cycle the assertions check the following properties of the output and its internal state. The rise strobe is a single cycle, coincides with a rising `clkOut`, and never appears while bypass is active. The setting in use changes only at a load point. The counter stays frozen in low-power mode. The actual phase lengths, the deferral of a setting written mid-period, and the startup timing after reset and after bypass are shown only by the bench. It measures the high and low phases for all 256 settings and for seeded random settings, and it runs directed scenarios for writes during the high phase and during bypass.

// File: rtl/phase_clk_div_pkg.sv
`timescale 1ns/1ps
package phase_clk_div_pkg;
  // Strobes issued by the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic loadCfg;   // adopt the pending setting
    logic startHigh; // begin a high phase
    logic startLow;  // begin a low phase
    logic holdIdle;  // freeze counter, force output low
  } divCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/phase_clk_div_ctrl.sv
`timescale 1ns/1ps
module phase_clk_div_ctrl
  import phase_clk_div_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lowPowerMode,
  input  logic    phaseDone,
  output divCtl_t ctl
);

  phase_e state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    if (lowPowerMode) begin
      ctl.holdIdle = 1'b1;
      stateNext    = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          ctl.startHigh = 1'b1;
          ctl.loadCfg   = 1'b1;
          stateNext     = ST_HIGH;
        end
        ST_HIGH: begin
          if (phaseDone) begin
            ctl.startLow = 1'b1;
            stateNext    = ST_LOW;
          end
        end
        ST_LOW: begin
          if (phaseDone) begin
            ctl.startHigh = 1'b1;
            ctl.loadCfg   = 1'b1;
            stateNext     = ST_HIGH;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // R6: the setting is adopted only when a high phase begins
  assert_load_with_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadCfg |-> ctl.startHigh);

  // R5: at most one phase action per cycle
  assert_single_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.startHigh, ctl.startLow, ctl.holdIdle}));

  // R8: low-power mode leaves the sequencer idle
  assert_idle_in_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lowPowerMode |=> (state == ST_IDLE));

endmodule

// File: rtl/phase_clk_div_dp.sv
`timescale 1ns/1ps
module phase_clk_div_dp
  import phase_clk_div_pkg::*;
#(
  parameter  int NIB_W = 4,
  localparam int CFG_W = 2 * NIB_W,
  localparam int DIV_W = NIB_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  divCtl_t          ctl,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             lowPowerMode,
  output logic             phaseDone,
  output logic             clkOut,
  output logic             riseStrobe,
  output logic [DIV_W-1:0] divisorOut,
  output logic             bypassActive
);

  logic [CFG_W-1:0] pendingCfg, activeCfg;
  logic [NIB_W-1:0] phaseCnt;
  logic [NIB_W-1:0] pendHigh, actLow, actHigh;

  assign pendHigh  = pendingCfg[CFG_W-1:NIB_W];
  assign actHigh   = activeCfg[CFG_W-1:NIB_W];
  assign actLow    = activeCfg[NIB_W-1:0];
  assign phaseDone = (phaseCnt == '0);

  // Pending setting: accepts writes at any time
  always_ff @(posedge clk) begin
    if (!rst_n)       pendingCfg <= '0;
    else if (cfgWrEn) pendingCfg <= cfgWrData;
  end

  // Setting in use: changes only at a load point
  always_ff @(posedge clk) begin
    if (!rst_n)           activeCfg <= '0;
    else if (ctl.loadCfg) activeCfg <= pendingCfg;
  end

  // Phase counter: loaded with the field, counts down to zero
  always_ff @(posedge clk) begin
    if (!rst_n)                           phaseCnt <= '0;
    else if (ctl.holdIdle)                phaseCnt <= phaseCnt;
    else if (ctl.startHigh)               phaseCnt <= pendHigh;
    else if (ctl.startLow)                phaseCnt <= actLow;
    else if (phaseCnt != '0)              phaseCnt <= phaseCnt - 1'b1;
  end

  // Output registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkOut       <= 1'b0;
      riseStrobe   <= 1'b0;
      bypassActive <= 1'b0;
    end else begin
      riseStrobe   <= ctl.startHigh;
      bypassActive <= lowPowerMode;
      if (ctl.startHigh)                    clkOut <= 1'b1;
      else if (ctl.startLow || ctl.holdIdle) clkOut <= 1'b0;
    end
  end

  assign divisorOut = DIV_W'(actHigh) + DIV_W'(actLow) + DIV_W'(2);

  // R8: counter frozen while holding idle
  assert_hold_counter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.holdIdle |=> $stable(phaseCnt));

  // R6: setting in use is stable between load points
  assert_cfg_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.loadCfg |=> $stable(activeCfg));

  // R5: strobe lasts one cycle
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    riseStrobe |=> !riseStrobe);

  // R5: strobe coincides with the output going high
  assert_strobe_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkOut) |-> riseStrobe);

  assert_strobe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    riseStrobe |-> clkOut);

  // R8: output parked low during bypass
  assert_bypass_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypassActive |-> (!clkOut && !riseStrobe));

  // R7: divisor never below two
  assert_divisor_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    divisorOut >= DIV_W'(2));

endmodule

// File: rtl/phase_clk_div.sv
`timescale 1ns/1ps
module phase_clk_div
  import phase_clk_div_pkg::*;
#(
  parameter  int NIB_W = 4,
  localparam int CFG_W = 2 * NIB_W,
  localparam int DIV_W = NIB_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             lowPowerMode,
  output logic             clkOut,
  output logic             riseStrobe,
  output logic [DIV_W-1:0] divisorOut,
  output logic             bypassActive
);

  divCtl_t ctl;
  logic    phaseDone;

  phase_clk_div_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .lowPowerMode (lowPowerMode),
    .phaseDone    (phaseDone),
    .ctl          (ctl)
  );

  phase_clk_div_dp #(.NIB_W(NIB_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .lowPowerMode (lowPowerMode),
    .phaseDone    (phaseDone),
    .clkOut       (clkOut),
    .riseStrobe   (riseStrobe),
    .divisorOut   (divisorOut),
    .bypassActive (bypassActive)
  );

  // R4: leaving reset or bypass starts a high phase on the next edge
  assert_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowPowerMode && !clkOut && bypassActive) |=> riseStrobe);

endmodule

// File: tb/phase_clk_div_tb.sv
`timescale 1ns/1ps
module phase_clk_div_tb;
  localparam int NIB_W = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfgWrEn;
  logic [7:0] cfgWrData;
  logic       lowPowerMode;
  logic       clkOut, riseStrobe, bypassActive;
  logic [5:0] divisorOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  phase_clk_div #(.NIB_W(NIB_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .lowPowerMode(lowPowerMode), .clkOut(clkOut), .riseStrobe(riseStrobe),
    .divisorOut(divisorOut), .bypassActive(bypassActive)
  );

  function automatic int expHigh(input logic [7:0] c); return int'(c[7:4]) + 1; endfunction
  function automatic int expLow (input logic [7:0] c); return int'(c[3:0]) + 1; endfunction
  function automatic int expDiv (input logic [7:0] c); return expHigh(c) + expLow(c); endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic waitRise();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (riseStrobe) return;
    end
    check(1'b0, "R5 strobe timeout", 0, 1);
  endtask

  // Called at a negedge where the strobe is high; ends at the next strobe
  task automatic measure(output int hiN, output int loN, output int strobes);
    hiN = 0; loN = 0; strobes = 0;
    while (clkOut && hiN < 64) begin
      if (riseStrobe) strobes++;
      hiN++; @(negedge clk);
    end
    while (!clkOut && loN < 64) begin
      if (riseStrobe) strobes++;
      loN++; @(negedge clk);
    end
  endtask

  task automatic checkSetting(input logic [7:0] v);
    int hiN, loN, st, dv;
    writeCfg(v);
    waitRise(); waitRise();
    dv = int'(divisorOut);
    measure(hiN, loN, st);
    check(hiN == expHigh(v), "R1 high length", hiN, expHigh(v));
    check(loN == expLow(v),  "R2 low length",  loN, expLow(v));
    check(dv == expDiv(v),   "R7 divisor",     dv,  expDiv(v));
    check(st == 1 && riseStrobe, "R5 one strobe per period", st, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int hiN, loN, st, dv;
    logic [7:0] rv;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfgWrEn = 1'b0; cfgWrData = '0; lowPowerMode = 1'b0;
    repeat (3) @(negedge clk);
    // R3: reset state
    check(!clkOut,      "R3 clkOut low",    clkOut, 0);
    check(!riseStrobe,  "R3 strobe low",    riseStrobe, 0);
    check(!bypassActive,"R3 bypass low",    bypassActive, 0);
    check(divisorOut == 6'd2, "R3 divisor", divisorOut, 2);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: first enabled edge starts high phase
    check(clkOut && riseStrobe, "R4 first high phase", {clkOut, riseStrobe}, 3);
    measure(hiN, loN, st);
    check(hiN == 1 && loN == 1, "R3 default setting 0x00", hiN + loN, 2);

    // R1 R2 R7: full sweep of all settings
    for (int v = 0; v < 256; v++) checkSetting(8'(v));
    // R1 R2: seeded random settings
    for (int k = 0; k < 40; k++) begin
      rv = 8'($urandom);
      checkSetting(rv);
    end
    checkSetting(8'hFF);
    checkSetting(8'h00);

    // R6: write during a high phase does not alter the current period
    checkSetting(8'h77);
    cfgWrEn = 1'b1; cfgWrData = 8'h11; hiN = 0; loN = 0;
    while (clkOut && hiN < 64) begin hiN++; @(negedge clk); cfgWrEn = 1'b0; end
    dv = int'(divisorOut);
    while (!clkOut && loN < 64) begin loN++; @(negedge clk); end
    check(hiN == 8, "R6 old high kept", hiN, 8);
    check(loN == 8, "R6 old low kept",  loN, 8);
    check(dv == 16, "R7 divisor old during period", dv, 16);
    dv = int'(divisorOut);
    measure(hiN, loN, st);
    check(hiN == 2 && loN == 2, "R6 new setting next period", hiN + loN, 4);
    check(dv == 4, "R7 divisor after load", dv, 4);

    // R8: low-power bypass mid high phase
    checkSetting(8'h22);
    lowPowerMode = 1'b1;
    @(negedge clk);
    check(bypassActive, "R8 bypass flag", bypassActive, 1);
    check(!clkOut, "R8 output low", clkOut, 0);
    cfgWrEn = 1'b1; cfgWrData = 8'h21;
    @(negedge clk); cfgWrEn = 1'b0;
    st = 0;
    for (int i = 0; i < 20; i++) begin
      if (clkOut || riseStrobe || !bypassActive) st++;
      @(negedge clk);
    end
    check(st == 0, "R8 idle during bypass", st, 0);
    lowPowerMode = 1'b0;
    @(negedge clk);
    // R9: high phase starts on the next edge with the new setting
    check(clkOut && riseStrobe, "R9 restart", {clkOut, riseStrobe}, 3);
    check(!bypassActive, "R9 bypass cleared", bypassActive, 0);
    dv = int'(divisorOut);
    measure(hiN, loN, st);
    check(hiN == 3, "R9 high from bypass write", hiN, 3);
    check(loN == 2, "R9 low from bypass write",  loN, 2);
    check(dv == 5, "R7 divisor after bypass", dv, 5);

    summary();
    $finish;
  end
endmodule